// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block collects up to sixteen event lines from the rest of a processor core and decides which one to service next. Each line is sampled and watched for a rising edge. An edge is remembered in a latch register until the event is taken. Software chooses which events may be serviced through a mask register. The block keeps a pending register with one bit for every level that is active or nested. A new event is raised into the pending set only when its priority is higher than every level already pending. The core signals the end of a handler with a return strobe, which pops the innermost active level.

A small register port gives access to the latch, mask and pending registers. A supervisor flag gates this access. General-purpose levels, from a configurable index upward, can be switched on and off together by two command strobes, without touching the mask register.

Top module: `evt_ctrl`

## Requirements
- R1: After reset the latch, mask and pending registers are all zero, and the general-purpose enable is on.
- R2: A rising edge on event line i sets latch bit i at the second rising clock edge after the line is first sampled high. A line held high afterwards does not set the latch again.
- R3: With the event enabled and nothing pending, pending bit i sets at the third clock edge after the line is first sampled high, and latch bit i clears at that same edge.
- R4: A new rising edge on a line whose pending bit is already set latches again. That event is raised again after the return strobe frees its level.
- R5: A latched event whose mask bit is 0 is never raised, and its latch bit stays set. Once its mask bit is written to 1, the event is raised.
- R6: Bit 0 has the highest priority and priority falls as the index rises. Among enabled latched events, only the lowest index is raised, one per cycle. It is raised only if its index is lower than that of every pending bit.
- R7: A return strobe (ret_i high at a clock edge) clears the lowest-index set pending bit. No event is raised at an edge where ret_i is high.
- R8: Events with index at or above GP_FIRST (7 by default) are raised only while the general-purpose enable is on. gie_clr_i turns the enable off and gie_set_i turns it on. When both strobes are high at the same edge, clear wins.
- R9: The register address selects 0 for latch, 1 for mask and 2 for pending. Address 3 reads as zero. A write to the latch changes only the bits whose mask bit is 0.
- R10: Reading or writing the mask, and reading the pending register, require sup_i high. A denied read returns zero and a denied write is ignored. Writes to the pending register are always ignored. The latch may be accessed with sup_i low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event lines, level or pulse |
| ret_i | input | 1 | Return-from-event strobe |
| gie_set_i | input | 1 | Turn general-purpose events on |
| gie_clr_i | input | 1 | Turn general-purpose events off |
| sup_i | input | 1 | Supervisor mode flag |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | NUM_EVT | Register write data |
| reg_rdata_o | output | NUM_EVT | Register read data, combinational on the address |
| pend_o | output | NUM_EVT | Pending (active and nested) levels |

## Verification
The hardest states to reach from the ports are the ones where two actions fall on the same level at once. One case is a second edge arriving on an event that is already pending. Another is a return strobe landing in a cycle where a raise would otherwise happen. The bench reaches these in two ways. It pulses a line again during the pending window of the same event, and it holds ret_i high across the whole edge-to-raise latency. It also sweeps every ordered pair of event indices, raising one and then the other. This covers both nesting, where a higher priority event interrupts a lower one, and queueing, where a lower priority event waits until the return strobe.

// File: rtl/evt_pkg.sv
package evt_pkg;
  typedef enum logic [1:0] {
    RA_LATCH = 2'd0,
    RA_MASK  = 2'd1,
    RA_PEND  = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] smp_q;
  logic [W-1:0] dly_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_q[g] <= 1'b0;
        dly_q[g] <= 1'b0;
      end else begin
        smp_q[g] <= lvl_i[g];
        dly_q[g] <= smp_q[g];
      end
    end
    assign rise_o[g] = smp_q[g] & ~dly_q[g];
  end
endmodule

// File: rtl/evt_prio_pick.sv
module evt_prio_pick #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [W-1:0]  onehot_o
);
  // lowest index wins
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
    onehot_o = req_i & ~(req_i - W'(1));
  end
endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
  import evt_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         sup_i,
  input  logic         we_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] pend_i,
  output logic [W-1:0] latch_wr_o,
  output logic         mask_wr_o,
  output logic [W-1:0] rdata_o
);
  reg_addr_e sel;
  assign sel = reg_addr_e'(addr_i);

  always_comb begin
    latch_wr_o = '0;
    mask_wr_o  = 1'b0;
    if (we_i) begin
      case (sel)
        RA_LATCH: latch_wr_o = ~mask_i;
        RA_MASK:  mask_wr_o  = sup_i;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      RA_LATCH: rdata_o = latch_i;
      RA_MASK:  rdata_o = sup_i ? mask_i : '0;
      RA_PEND:  rdata_o = sup_i ? pend_i : '0;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl #(
  parameter int unsigned NUM_EVT  = 16,
  parameter int unsigned GP_FIRST = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ret_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               sup_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [NUM_EVT-1:0] reg_wdata_i,
  output logic [NUM_EVT-1:0] reg_rdata_o,
  output logic [NUM_EVT-1:0] pend_o
);
  localparam int unsigned IW = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic [NUM_EVT-1:0] latch_q, mask_q, pend_q;
  logic               gie_q;
  logic [NUM_EVT-1:0] rise, gate, cand;
  logic [NUM_EVT-1:0] cand_oh, pend_oh, raise_oh, latch_wr;
  logic [IW-1:0]      cand_idx, pend_idx;
  logic               cand_any, pend_any, raise, mask_wr;

  evt_edge_det #(.W(NUM_EVT)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (evt_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_gate
    if (g >= GP_FIRST) begin : g_gp
      assign gate[g] = gie_q;
    end else begin : g_fixed
      assign gate[g] = 1'b1;
    end
  end

  assign cand = latch_q & mask_q & gate;

  evt_prio_pick #(.W(NUM_EVT)) u_pick_cand (
    .req_i    (cand),
    .any_o    (cand_any),
    .idx_o    (cand_idx),
    .onehot_o (cand_oh)
  );

  evt_prio_pick #(.W(NUM_EVT)) u_pick_pend (
    .req_i    (pend_q),
    .any_o    (pend_any),
    .idx_o    (pend_idx),
    .onehot_o (pend_oh)
  );

  // a return edge never raises; raise only above current nesting
  assign raise    = cand_any && !ret_i && (!pend_any || (cand_idx < pend_idx));
  assign raise_oh = raise ? cand_oh : '0;

  evt_reg_port #(.W(NUM_EVT)) u_regs (
    .sup_i      (sup_i),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .latch_i    (latch_q),
    .mask_i     (mask_q),
    .pend_i     (pend_q),
    .latch_wr_o (latch_wr),
    .mask_wr_o  (mask_wr),
    .rdata_o    (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      gie_q   <= 1'b1;
    end else begin
      // a fresh edge overrides the clear of the bit being raised
      latch_q <= (latch_q & ~raise_oh & ~latch_wr) | (reg_wdata_i & latch_wr) | rise;
      pend_q  <= (pend_q & ~(ret_i ? pend_oh : '0)) | raise_oh;
      if (mask_wr) mask_q <= reg_wdata_i;
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/evt_ctrl_chk.sv
module evt_ctrl_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         ret_i,
  input logic         sup_i,
  input logic         reg_we_i,
  input logic [1:0]   reg_addr_i,
  input logic [W-1:0] latch_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] pend_q
);
  logic         v_q, prev_ret, prev_deny;
  logic [W-1:0] prev_pend, prev_lm, new_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q       <= 1'b0;
      prev_ret  <= 1'b0;
      prev_deny <= 1'b0;
      prev_pend <= '0;
      prev_lm   <= '0;
    end else begin
      v_q       <= 1'b1;
      prev_ret  <= ret_i;
      prev_deny <= reg_we_i && (reg_addr_i == 2'd1) && !sup_i;
      prev_pend <= pend_q;
      prev_lm   <= latch_q & mask_q;
    end
  end

  assign new_b = pend_q & ~prev_pend;

  AST_ONE_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |-> ($countones(new_b) <= 1)); // R6
  AST_RAISE_NEEDS_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_q |-> ((new_b & ~prev_lm) == '0)); // R5
  AST_NEST_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && (new_b != '0)) |-> (((new_b - W'(1)) & prev_pend) == '0)); // R6
  AST_RET_POPS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && prev_ret && (prev_pend != '0)) |-> ($countones(prev_pend & ~pend_q) == 1)); // R7
  AST_NO_RAISE_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && prev_ret) |-> (new_b == '0)); // R7
  AST_MASK_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_q && prev_deny) |-> $stable(mask_q)); // R10
endmodule

bind evt_ctrl evt_ctrl_chk #(.W(NUM_EVT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ret_i      (ret_i),
  .sup_i      (sup_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .latch_q    (latch_q),
  .mask_q     (mask_q),
  .pend_q     (pend_q)
);

// File: tb/evt_ctrl_bench.sv
`timescale 1ns/1ps
module evt_ctrl_bench;
  localparam int N  = 16;
  localparam int GP = 7;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] evt = '0;
  logic         ret = 1'b0, gset = 1'b0, gclr = 1'b0, sup = 1'b1, we = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pend;
  int           n_chk = 0, n_fail = 0;
  logic [N-1:0] r;

  always #2.5 clk = ~clk;

  evt_ctrl #(.NUM_EVT(N), .GP_FIRST(GP)) u_evt_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .ret_i       (ret),
    .gie_set_i   (gset),
    .gie_clr_i   (gclr),
    .sup_i       (sup),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pend_o      (pend)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d, input logic s);
    addr = a; wdata = d; sup = s; we = 1'b1;
    @(negedge clk);
    we = 1'b0; sup = 1'b1;
  endtask

  task automatic rd(input logic [1:0] a, input logic s, output logic [N-1:0] d);
    addr = a; sup = s;
    #0.1;
    d = rdata;
    sup = 1'b1;
  endtask

  task automatic pulse(input logic [N-1:0] bits);
    evt = evt | bits;
    @(negedge clk);
    evt = evt & ~bits;
  endtask

  task automatic pop();
    ret = 1'b1;
    @(negedge clk);
    ret = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    nclk(3);
    rst_ni = 1'b1;
    nclk(1);
    // R1 reset state
    rd(2'd0, 1'b1, r); chk("R1 latch", r, '0);
    rd(2'd1, 1'b1, r); chk("R1 mask", r, '0);
    rd(2'd2, 1'b1, r); chk("R1 pend", r, '0);
    chk("R1 pend_o", pend, '0);

    // R10 supervisor gating, R9 latch write gating
    wr(2'd1, 16'hFFFF, 1'b0);
    rd(2'd1, 1'b1, r); chk("R10 denied mask write", r, '0);
    wr(2'd1, 16'h00F0, 1'b1);
    rd(2'd1, 1'b0, r); chk("R10 denied mask read", r, '0);
    rd(2'd1, 1'b1, r); chk("R10 mask read", r, 16'h00F0);
    wr(2'd0, 16'hFFFF, 1'b0);
    rd(2'd0, 1'b0, r); chk("R9 latch write only mask-clear bits", r, 16'hFF0F);
    nclk(3);
    chk("R5 masked latched not raised", pend, '0);
    rd(2'd0, 1'b0, r); chk("R5 masked latch kept", r, 16'hFF0F);
    wr(2'd2, 16'hFFFF, 1'b1);
    rd(2'd2, 1'b1, r); chk("R10 pend write ignored", r, '0);
    rd(2'd3, 1'b1, r); chk("R9 addr 3 reads zero", r, '0);
    wr(2'd0, 16'h0000, 1'b1);
    rd(2'd0, 1'b1, r); chk("R9 latch cleared", r, '0);

    // R5 mask enabling a held latch
    wr(2'd1, 16'hFEFF, 1'b1);
    pulse(16'h0100); nclk(4);
    chk("R5 masked bit8 pend", pend, '0);
    rd(2'd0, 1'b1, r); chk("R5 masked bit8 latch", r, 16'h0100);
    wr(2'd1, 16'hFFFF, 1'b1);
    nclk(1);
    chk("R5 unmask raises", pend, 16'h0100);
    pop();

    // R2 R3 latency sweep, line held high
    for (int i = 0; i < N; i++) begin
      evt[i] = 1'b1;
      nclk(1);
      rd(2'd0, 1'b1, r); chk("R2 not yet latched", r, '0);
      nclk(1);
      rd(2'd0, 1'b1, r); chk("R2 latched", r, N'(1) << i);
      chk("R3 not yet pending", pend, '0);
      nclk(1);
      chk("R3 pending", pend, N'(1) << i);
      rd(2'd0, 1'b1, r); chk("R3 latch cleared", r, '0);
      if (i == GP) chk("R1 gp enable on after reset", pend, N'(1) << i);
      nclk(4);
      rd(2'd0, 1'b1, r); chk("R2 level does not relatch", r, '0);
      pop();
      chk("R7 pop single", pend, '0);
      evt[i] = 1'b0;
      nclk(2);
    end

    // R6 R7 pair sweep
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        if (a != b) begin
          pulse(N'(1) << a); nclk(2);
          pulse(N'(1) << b); nclk(2);
          if (b < a) begin
            chk("R6 nested", pend, (N'(1) << a) | (N'(1) << b));
            pop();
            chk("R7 pops lowest", pend, N'(1) << a);
            pop();
            chk("R7 pops last", pend, '0);
          end else begin
            chk("R6 lower prio waits", pend, N'(1) << a);
            pop();
            chk("R7 no raise on ret edge", pend, '0);
            nclk(1);
            chk("R6 queued raised", pend, N'(1) << b);
            pop();
          end
        end
      end
    end

    // R6 simultaneous candidates
    pulse(16'h0208); nclk(2);
    chk("R6 simultaneous lowest wins", pend, 16'h0008);
    nclk(2);
    chk("R6 higher index waits", pend, 16'h0008);
    pop(); nclk(1);
    chk("R6 next raised", pend, 16'h0200);
    pop();

    // R4 re-edge while pending
    pulse(16'h0010); nclk(2);
    chk("R4 first raise", pend, 16'h0010);
    pulse(16'h0010); nclk(1);
    rd(2'd0, 1'b1, r); chk("R4 relatched", r, 16'h0010);
    chk("R4 still single pending", pend, 16'h0010);
    pop();
    chk("R4 popped", pend, '0);
    nclk(1);
    chk("R4 served again", pend, 16'h0010);
    rd(2'd0, 1'b1, r); chk("R4 latch cleared", r, '0);
    pop();

    // R7 return held blocks raise
    ret = 1'b1;
    pulse(16'h0040); nclk(5);
    chk("R7 no raise while ret", pend, '0);
    rd(2'd0, 1'b1, r); chk("R7 latched under ret", r, 16'h0040);
    ret = 1'b0;
    nclk(1);
    chk("R7 raise after ret", pend, 16'h0040);
    pop();

    // R8 general-purpose enable
    gclr = 1'b1; nclk(1); gclr = 1'b0;
    pulse(16'h0400); nclk(4);
    chk("R8 gp blocked", pend, '0);
    pulse(16'h0040); nclk(2);
    chk("R8 below GP_FIRST unaffected", pend, 16'h0040);
    pop(); nclk(2);
    chk("R8 gp still blocked", pend, '0);
    gset = 1'b1; gclr = 1'b1; nclk(1); gset = 1'b0; gclr = 1'b0;
    nclk(2);
    chk("R8 clear wins", pend, '0);
    gset = 1'b1; nclk(1); gset = 1'b0;
    nclk(1);
    chk("R8 gp released", pend, 16'h0400);
    pop();
    chk("R8 done", pend, '0);

    finish_run();
  end
endmodule